// File: doc/BRIEF.md
# Cycle-Stealing Block Mover

This block is a single-channel engine that copies a run of words from one region of a shared memory bus to another. The processor is the normal owner of that bus. It programs a source address, a destination address, a word count, a per-tenure block size and a tenure style, and then issues a start command. The engine asks for the bus on its own request/grant pair. It copies words while it is granted and raises an interrupt level once the whole count has been moved.

Two tenure styles can be chosen. In the first, the engine keeps the bus from the first word to the last. In the second, it gives the bus back after every block of words, so the processor gets bus cycles between blocks. Every bus access is held until the slave answers with a ready pulse, so memories with any latency can be used. A zero count finishes at once and never touches the bus.

Top module: `dma_steal_ctrl`

## Requirements
- R1: When idle, writes at config addresses 0 (source), 1 (destination), 2 (word count) and 3 (block size) read back unchanged at the same address. Address 4 reads status: bit 0 busy, bit 1 done, bit 2 tenure style, bits 15:8 remaining word count.
- R2: A write to address 4 with bit 0 set starts a copy. For a nonzero count, `bus_req` rises and then stays high until `bus_gnt` is seen high. No bus access is issued while the grant is low.
- R3: Word i is read from source+i and then written to destination+i, in increasing order. An access holds `m_valid`, `m_addr`, `m_we` and `m_wdata` steady until `m_ready` is seen. Memory beyond the counted words is left unchanged.
- R4: With bit 1 of the start write set (hold style), a nonzero copy uses exactly one bus tenure.
- R5: With bit 1 clear (stealing style), the bus is released after every block. The copy uses ceil(count/block) tenures, and no tenure carries more than block words. A block size of 0 acts as 1.
- R6: After a release, `bus_req` stays low until `bus_gnt` has been seen low.
- R7: When the last word is written and the bus is released, `irq` and status done go high, busy goes low and remaining reads 0.
- R8: A start with count 0 sets done and `irq` without ever raising `bus_req`.
- R9: While busy, every config write is ignored, a second start included.
- R10: A write to address 4 with bit 2 set, while idle, clears done and `irq`.
- R11: After reset, status reads 0, and `bus_req`, `m_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_addr | input | 3 | Config word select |
| cfg_wdata | input | DW | Config write data |
| cfg_rdata | output | DW | Config read data (combinational on cfg_addr) |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| m_valid | output | 1 | Bus access pending |
| m_we | output | 1 | Access is a write |
| m_addr | output | AW | Access word address |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, valid with m_ready |
| m_ready | input | 1 | Slave completes the access |
| irq | output | 1 | Completion interrupt level |

## Verification
Several rules are checked on every cycle by the assertions. They cover the request/grant rules, accesses issued only under grant, an access held steady until ready, frozen configuration while busy, the block limit inside one tenure, and done only at a zero remaining count. Other rules can only be shown by the bench's scenarios. These are the copied data and the untouched guard word, the number of tenures per style and block size, the zero-count path, and ignored writes during a copy. The bench sweeps every count from 0 to 6 against every block size from 0 to 3 in both styles, with grant delays and slave latencies that change from run to run.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_WAIT,
        ENG_RD,
        ENG_WR,
        ENG_PAUSE
    } eng_state_e;

    typedef enum logic [1:0] {
        OWN_OFF,
        OWN_ASK,
        OWN_HELD,
        OWN_DROP
    } own_state_e;

    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_LEN  = 3'd2;
    localparam logic [2:0] RA_BLK  = 3'd3;
    localparam logic [2:0] RA_CTRL = 3'd4;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_HOLD = 1;
    localparam int CTRL_CLR  = 2;
    localparam int STAT_REM  = 8;

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          busy,
    input  logic          done,
    input  logic [LW-1:0] remaining,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [LW-1:0] len,
    output logic [LW-1:0] blk,
    output logic          hold,
    output logic          go,
    output logic          clr
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [LW-1:0] len;
        logic [LW-1:0] blk;
        logic          hold;
    } cfg_t;

    cfg_t cfg_q, cfg_d;
    logic wr_ok;

    always_comb begin
        cfg_d = cfg_q;
        wr_ok = wr && !busy;
        go    = wr_ok && (addr == RA_CTRL) && wdata[CTRL_GO];
        clr   = wr_ok && (addr == RA_CTRL) && wdata[CTRL_CLR];
        if (wr_ok) begin
            case (addr)
                RA_SRC:  cfg_d.src  = wdata[AW-1:0];
                RA_DST:  cfg_d.dst  = wdata[AW-1:0];
                RA_LEN:  cfg_d.len  = wdata[LW-1:0];
                RA_BLK:  cfg_d.blk  = wdata[LW-1:0];
                RA_CTRL: cfg_d.hold = wdata[CTRL_HOLD];
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_SRC:  rdata[AW-1:0] = cfg_q.src;
            RA_DST:  rdata[AW-1:0] = cfg_q.dst;
            RA_LEN:  rdata[LW-1:0] = cfg_q.len;
            RA_BLK:  rdata[LW-1:0] = cfg_q.blk;
            RA_CTRL: begin
                rdata[0]                = busy;
                rdata[1]                = done;
                rdata[2]                = cfg_q.hold;
                rdata[STAT_REM +: LW]   = remaining;
            end
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign src  = cfg_q.src;
    assign dst  = cfg_q.dst;
    assign len  = cfg_q.len;
    assign blk  = cfg_q.blk;
    assign hold = cfg_q.hold;

    // R9: configuration frozen while a copy runs
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr) |=> $stable(cfg_q));

endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic gnt,
    output logic req,
    output logic own,
    output logic free
);

    typedef struct packed {
        own_state_e st;
    } own_t;

    own_t own_q, own_d;

    always_comb begin
        own_d = own_q;
        case (own_q.st)
            OWN_OFF:  if (want && !gnt) own_d.st = OWN_ASK;
            OWN_ASK:  if (gnt)          own_d.st = OWN_HELD;
            OWN_HELD: if (!want)        own_d.st = OWN_DROP;
            OWN_DROP: if (!gnt)         own_d.st = OWN_OFF;
            default:                    own_d.st = OWN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) own_q <= '0;
        else        own_q <= own_d;
    end

    assign req  = (own_q.st == OWN_ASK) || (own_q.st == OWN_HELD);
    assign own  = (own_q.st == OWN_HELD);
    assign free = (own_q.st == OWN_OFF);

    // R2: request held until grant appears
    a_r2_req_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> req);

    // R6: no new request while the previous grant is still up
    a_r6_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && gnt) |=> !req);

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          clr,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [LW-1:0] len,
    input  logic [LW-1:0] blk,
    input  logic          hold,
    input  logic          own,
    input  logic          free,
    output logic          want,
    output logic          m_valid,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready,
    output logic          busy,
    output logic          done,
    output logic [LW-1:0] remaining
);

    typedef struct packed {
        eng_state_e    st;
        logic [AW-1:0] sp;
        logic [AW-1:0] dp;
        logic [LW-1:0] rem;
        logic [LW-1:0] beat;
        logic [DW-1:0] data;
        logic          done;
    } eng_t;

    eng_t eng_q, eng_d;
    logic [LW-1:0] blk_eff;
    logic [LW-1:0] beat_nx;

    always_comb begin
        blk_eff = (blk == '0) ? LW'(1) : blk;
        beat_nx = eng_q.beat + LW'(1);
        eng_d   = eng_q;
        want    = 1'b0;
        m_valid = 1'b0;
        m_we    = 1'b0;
        m_addr  = eng_q.sp;
        m_wdata = eng_q.data;
        case (eng_q.st)
            ENG_IDLE: begin
                if (go) begin
                    eng_d.done = (len == '0);
                    eng_d.sp   = src;
                    eng_d.dp   = dst;
                    eng_d.rem  = len;
                    eng_d.beat = '0;
                    if (len != '0) eng_d.st = ENG_WAIT;
                end else if (clr) begin
                    eng_d.done = 1'b0;
                end
            end
            ENG_WAIT: begin
                want       = 1'b1;
                eng_d.beat = '0;
                if (own) eng_d.st = ENG_RD;
            end
            ENG_RD: begin
                want    = 1'b1;
                m_valid = 1'b1;
                m_addr  = eng_q.sp;
                if (m_ready) begin
                    eng_d.data = m_rdata;
                    eng_d.st   = ENG_WR;
                end
            end
            ENG_WR: begin
                want    = 1'b1;
                m_valid = 1'b1;
                m_we    = 1'b1;
                m_addr  = eng_q.dp;
                if (m_ready) begin
                    eng_d.sp   = eng_q.sp + AW'(1);
                    eng_d.dp   = eng_q.dp + AW'(1);
                    eng_d.rem  = eng_q.rem - LW'(1);
                    eng_d.beat = beat_nx;
                    if ((eng_q.rem == LW'(1)) || (!hold && (beat_nx >= blk_eff)))
                        eng_d.st = ENG_PAUSE;
                    else
                        eng_d.st = ENG_RD;
                end
            end
            ENG_PAUSE: begin
                if (free) begin
                    if (eng_q.rem == '0) begin
                        eng_d.st   = ENG_IDLE;
                        eng_d.done = 1'b1;
                    end else begin
                        eng_d.st = ENG_WAIT;
                    end
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy      = (eng_q.st != ENG_IDLE);
    assign done      = eng_q.done;
    assign remaining = eng_q.rem;

    // R5: a stealing tenure never exceeds the block size
    a_r5_block_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.st == ENG_RD && !hold) |-> (eng_q.beat < blk_eff));

    // R7: done only with nothing left to move
    a_r7_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (remaining == '0));

    // R8: zero count finishes without wanting the bus
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (go && len == '0 && !busy) |=> (!want && done));

endmodule

// File: rtl/dma_steal_ctrl.sv
module dma_steal_ctrl
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          m_valid,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready,
    output logic          irq
);

    logic [AW-1:0] c_src, c_dst;
    logic [LW-1:0] c_len, c_blk, rem;
    logic          c_hold, go, clr, busy, done;
    logic          want, own, free;

    dma_cfg_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .busy(busy), .done(done),
        .remaining(rem), .src(c_src), .dst(c_dst), .len(c_len),
        .blk(c_blk), .hold(c_hold), .go(go), .clr(clr)
    );

    dma_bus_owner u_owner (
        .clk(clk), .rst_n(rst_n), .want(want), .gnt(bus_gnt),
        .req(bus_req), .own(own), .free(free)
    );

    dma_engine #(.AW(AW), .DW(DW), .LW(LW)) u_eng (
        .clk(clk), .rst_n(rst_n), .go(go), .clr(clr), .src(c_src),
        .dst(c_dst), .len(c_len), .blk(c_blk), .hold(c_hold), .own(own),
        .free(free), .want(want), .m_valid(m_valid), .m_we(m_we),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ready(m_ready), .busy(busy), .done(done), .remaining(rem)
    );

    assign irq = done;

    // R2: accesses only while granted
    a_r2_owned_bus: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> bus_gnt);

    // R3: a pending access stays put until the slave answers
    a_r3_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

endmodule

// File: tb/dma_steal_ctrl_test.sv
`timescale 1ns/1ps
module dma_steal_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        bus_req, bus_gnt;
    logic        m_valid, m_we, m_ready;
    logic [15:0] m_addr, m_wdata, m_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int gdelay = 0;
    int lat_sel = 0;
    int gcnt, lcnt;
    logic        fill_go = 1'b0;
    int          fill_seed = 0;
    logic [15:0] mem [0:255];

    int tenures = 0, req_cycles = 0, bad_valid = 0;
    int cur_beats = 0, max_beats = 0, epoch = 0, seen_epoch = 0;
    logic gnt_prev = 1'b0;

    always #2.5 clk = ~clk;

    dma_steal_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .m_valid(m_valid), .m_we(m_we), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .irq(irq)
    );

    // arbiter: grants after gdelay cycles, withdraws once request drops
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0; gcnt <= 0;
        end else if (bus_req && !bus_gnt) begin
            if (gcnt >= gdelay) begin bus_gnt <= 1'b1; gcnt <= 0; end
            else gcnt <= gcnt + 1;
        end else if (!bus_req) begin
            bus_gnt <= 1'b0; gcnt <= 0;
        end
    end

    // slave memory with address-dependent latency
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ready <= 1'b0; m_rdata <= 16'd0; lcnt <= 0;
        end else begin
            m_ready <= 1'b0;
            if (fill_go) begin
                for (int i = 0; i < 256; i++) mem[i] <= 16'(fill_seed * 256 + i);
            end else if (m_valid && !m_ready) begin
                if (lcnt >= (int'(m_addr[1:0]) ^ (lat_sel & 3))) begin
                    m_ready <= 1'b1; lcnt <= 0;
                    if (m_we) mem[m_addr[7:0]] <= m_wdata;
                    else      m_rdata <= mem[m_addr[7:0]];
                end else lcnt <= lcnt + 1;
            end
        end
    end

    // observer, sampled away from the active edge
    always @(negedge clk) begin
        if (seen_epoch != epoch) begin seen_epoch = epoch; max_beats = 0; end
        if (bus_gnt && !gnt_prev) begin tenures++; cur_beats = 0; end
        gnt_prev = bus_gnt;
        if (m_valid && m_ready && m_we) begin
            cur_beats++;
            if (cur_beats > max_beats) max_beats = cur_beats;
        end
        if (bus_req) req_cycles++;
        if (m_valid && !bus_gnt) bad_valid++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        cfg_addr = a;
        #1 v = cfg_rdata;
    endtask

    task automatic fill(input int seed);
        @(negedge clk);
        fill_seed = seed; fill_go = 1'b1;
        @(negedge clk);
        fill_go = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic run_one(input int len, input int blk, input bit hold, input int idx);
        int t0, q0, b0, be, exp_t, exp_m, bad, first;
        logic [15:0] st;
        be = (blk == 0) ? 1 : blk;
        gdelay = idx % 3; lat_sel = idx % 4;
        fill(idx + 1);
        wr(3'd0, 16'h0010); wr(3'd1, 16'h0080);
        wr(3'd2, 16'(len)); wr(3'd3, 16'(blk));
        epoch++;
        @(negedge clk);
        t0 = tenures; q0 = req_cycles; b0 = bad_valid;
        wr(3'd4, 16'(1 + (hold ? 2 : 0)));
        wait_irq();
        bad = 0; first = 0;
        for (int i = 0; i < len; i++)
            if (mem[8'h80 + i] !== 16'((idx + 1) * 256 + 16 + i)) begin
                if (bad == 0) first = int'(mem[8'h80 + i]);
                bad++;
            end
        chk(bad == 0, "R3", "copied words (first wrong value shown)", first, 0);
        chk(mem[8'h80 + len] === 16'((idx + 1) * 256 + 128 + len), "R3", "guard word",
            int'(mem[8'h80 + len]), (idx + 1) * 256 + 128 + len);
        exp_t = (len == 0) ? 0 : (hold ? 1 : (len + be - 1) / be);
        exp_m = (len == 0) ? 0 : (hold ? len : ((len < be) ? len : be));
        chk(tenures - t0 == exp_t, hold ? "R4" : "R5", "tenure count", tenures - t0, exp_t);
        chk(max_beats == exp_m, "R5", "largest tenure in words", max_beats, exp_m);
        chk(bad_valid == b0, "R2", "accesses without grant", bad_valid - b0, 0);
        if (len == 0) chk(req_cycles == q0, "R8", "request cycles on zero count", req_cycles - q0, 0);
        rd(3'd4, st);
        chk(st[1:0] == 2'b10 && st[15:8] == 8'd0 && irq, "R7", "status after completion",
            int'(st), 2 + (hold ? 4 : 0));
        chk(!bus_req, "R6", "request low after finish", int'(bus_req), 0);
    endtask

    initial begin
        logic [15:0] v;
        int t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd(3'd4, v);
        chk(v == 16'd0, "R11", "status after reset", int'(v), 0);
        chk(!bus_req && !m_valid && !irq, "R11", "outputs after reset",
            int'({bus_req, m_valid, irq}), 0);
        // R1 readback
        wr(3'd0, 16'h1234); wr(3'd1, 16'h00AB); wr(3'd2, 16'd5); wr(3'd3, 16'd3);
        rd(3'd0, v); chk(v == 16'h1234, "R1", "source readback", int'(v), 'h1234);
        rd(3'd1, v); chk(v == 16'h00AB, "R1", "destination readback", int'(v), 'hAB);
        rd(3'd2, v); chk(v == 16'd5, "R1", "count readback", int'(v), 5);
        rd(3'd3, v); chk(v == 16'd3, "R1", "block readback", int'(v), 3);
        // sweep: R3 R4 R5 R7 R8
        begin
            int idx = 0;
            for (int h = 0; h < 2; h++)
                for (int b = 0; b < 4; b++)
                    for (int l = 0; l < 7; l++) begin
                        run_one(l, b, h[0], idx);
                        if (idx == 5) begin
                            rd(3'd4, v);
                            chk(v[2] == 1'b0, "R1", "style bit in status", int'(v[2]), 0);
                        end
                        idx++;
                    end
        end
        // R10 clear done
        wr(3'd4, 16'd4);
        rd(3'd4, v);
        chk(v[1] == 1'b0 && !irq, "R10", "done after clear", int'({v[1], irq}), 0);
        // R9 writes during a copy are ignored
        gdelay = 2; lat_sel = 3;
        fill(200);
        wr(3'd0, 16'h0010); wr(3'd1, 16'h0080); wr(3'd2, 16'd6); wr(3'd3, 16'd1);
        @(negedge clk);
        t0 = tenures;
        wr(3'd4, 16'd1);
        repeat (3) @(negedge clk);
        rd(3'd4, v);
        chk(v[0] == 1'b1, "R9", "busy during copy", int'(v[0]), 1);
        wr(3'd0, 16'h0055); wr(3'd2, 16'd2); wr(3'd4, 16'd7);
        wait_irq();
        rd(3'd0, v); chk(v == 16'h0010, "R9", "source after busy write", int'(v), 'h10);
        rd(3'd2, v); chk(v == 16'd6, "R9", "count after busy write", int'(v), 6);
        chk(tenures - t0 == 6, "R9", "tenures after ignored restart", tenures - t0, 6);
        chk(mem[8'h85] === 16'(200 * 256 + 21), "R9", "last word copied",
            int'(mem[8'h85]), 200 * 256 + 21);
        rd(3'd4, v);
        chk(v[2] == 1'b0, "R9", "style bit after busy write", int'(v[2]), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R7: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule